// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer. It watches a 16-bit counter that is shared with other channels and is driven from outside the block. The channel runs in one of two modes. In capture mode it synchronizes an external pin, looks for the edge that software has selected, and stores the counter value in its channel register when that edge occurs. In compare mode it signals an event when the counter reaches the value held in the channel register.

An event from either mode sets a sticky event flag. When the channel's interrupt enable is high, the flag drives a level interrupt. Software clears the flag in two steps: it first reads the flag while the flag is set, then writes a zero to it. An event that arrives between those two steps, or in the same cycle as the write, keeps the flag set, so no event is lost.

Top module: `capcmp_channel`

## Requirements
- R1: After reset, `flag_o`, `irq_o` and `chan_val_o` are all 0.
- R2: In capture mode (`mode_cmp_i`=0), `edge_sel_i` selects the capturing edge of `pin_i`: 2'b00 means none (channel off), 2'b01 rising, 2'b10 falling, 2'b11 either. An edge that is not selected, and a counter equal to the channel value, leave the flag and the register unchanged.
- R3: A selected pin edge sets the flag on the third rising clock edge after the pin changes (two synchronizer flops, then one edge stage). The channel register takes `cnt_i` as sampled at that same clock edge.
- R4: In compare mode (`mode_cmp_i`=1), the flag sets on the clock edge where `cnt_i` equals `chan_val_o`, provided the two were not equal on the previous edge. A counter held at the match value does not set the flag again. Pin edges have no effect in this mode.
- R5: `wr_val_i` loads `wr_data_i` into the channel register. If a capture happens in the same cycle, the captured counter value wins.
- R6: `wr0_i` clears the flag only if an earlier `rd_i` saw the flag set and no event has occurred since that read. Idle cycles may separate the read and the write. A write of zero with no such read leaves the flag at 1.
- R7: An event after the arming read, including one in the same cycle as `wr0_i`, leaves the flag at 1 after the write.
- R8: `irq_o` is high exactly when `int_en_i` and the flag are both 1.
- R9: Once set, the flag stays at 1 through further events until a valid clear sequence removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared timer counter value |
| pin_i | input | 1 | Asynchronous capture pin |
| mode_cmp_i | input | 1 | 1 = compare mode, 0 = capture mode |
| edge_sel_i | input | 2 | Capture edge select (00 off, 01 rise, 10 fall, 11 both) |
| int_en_i | input | 1 | Interrupt enable |
| wr_val_i | input | 1 | Write strobe for the channel register |
| wr_data_i | input | 16 | Data for the channel register |
| rd_i | input | 1 | Software read of the flag |
| wr0_i | input | 1 | Software write of zero to the flag |
| chan_val_o | output | 16 | Channel register (captured or compare value) |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The capture path is swept over all four edge-select codes against both a rising and a falling pin transition. This separates each encoding from its neighbours and confirms the three-edge latency, using a counter that keeps running so that the captured value pins down the exact cycle of the capture. Compare mode is driven by a counter stepping through several targets, including 0 and the wrap at 0xFFFF, and separately by a counter held at the match value, which tells a rising-match detector apart from a level one. The clear sequence is exercised in several forms: a write with no prior read, a read then a write with idle cycles between, an event between the read and the write, and an event in the same cycle as the write. Together these show that the arming state is discarded at exactly the right moments.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Selected-edge test on a synchronized sample pair
  function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
    case (sel)
      EDGE_OFF:  return 1'b0;
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      default:   return cur ^ prev;
    endcase
  endfunction

  // Compare hit: equal now, and not equal on the previous edge
  function automatic logic value_hit(logic eq_now, logic eq_before);
    return eq_now & ~eq_before;
  endfunction

endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det
  import capcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      evt_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] chain;
  logic          cur, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign cur   = chain[LAST-1];
  assign prev  = chain[LAST];
  assign evt_o = edge_hit(sel_i, prev, cur);

  // R2
  edge_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (cur != $past(cur)));

endmodule

// File: rtl/cc_match.sv
module cc_match
  import capcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] val_i,
  output logic         evt_o
);
  logic eq_now, eq_q;

  assign eq_now = en_i && (cnt_i == val_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end

  assign evt_o = value_hit(eq_now, eq_q);

endmodule

// File: rtl/cc_flag.sv
module cc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic flag_o,
  output logic armed_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_o <= 1'b0;
    end else if (wr0_i && armed_o) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed_o <= 1'b1;
    end
  end

  // R6
  arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |-> flag_o);

  // R6
  clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> ($past(wr0_i) && !$past(set_i)));

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         pin_i,
  input  logic         mode_cmp_i,
  input  logic [1:0]   edge_sel_i,
  input  logic         int_en_i,
  input  logic         wr_val_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  input  logic         wr0_i,
  output logic [W-1:0] chan_val_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic pin_evt, evt_cap, evt_cmp, evt_any, armed;

  cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .sel_i (edge_sel_e'(edge_sel_i)),
    .evt_o (pin_evt)
  );

  cc_match #(.W(W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (mode_cmp_i),
    .cnt_i (cnt_i),
    .val_i (chan_val_o),
    .evt_o (evt_cmp)
  );

  assign evt_cap = pin_evt && !mode_cmp_i;
  assign evt_any = evt_cap || evt_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chan_val_o <= '0;
    else if (evt_cap)  chan_val_o <= cnt_i;
    else if (wr_val_i) chan_val_o <= wr_data_i;
  end

  cc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_any),
    .rd_i    (rd_i),
    .wr0_i   (wr0_i),
    .flag_o  (flag_o),
    .armed_o (armed)
  );

  assign irq_o = int_en_i && flag_o;

  // R3
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> (chan_val_o == $past(cnt_i)) && flag_o);

  // R9
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> flag_o);

  // R4
  cmp_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmp |-> (mode_cmp_i && cnt_i == chan_val_o));

endmodule

// File: tb/capcmp_channel_tb.sv
module capcmp_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0;
  logic        pin = 1'b0, mode_cmp = 1'b0, int_en = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        wr_val = 1'b0, rd = 1'b0, wr0 = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] chan_val;
  logic        flag, irq;
  logic        inc = 1'b0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin),
    .mode_cmp_i(mode_cmp), .edge_sel_i(edge_sel), .int_en_i(int_en),
    .wr_val_i(wr_val), .wr_data_i(wr_data), .rd_i(rd), .wr0_i(wr0),
    .chan_val_o(chan_val), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (inc) cnt = cnt + 16'd1;
  endtask

  task automatic clear_flag();
    rd = 1'b1; step(); rd = 1'b0;
    wr0 = 1'b1; step(); wr0 = 1'b0;
  endtask

  task automatic write_val(input logic [15:0] v);
    wr_data = v; wr_val = 1'b1; step(); wr_val = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] c0, prev, tgt, cur;
    bit exp_f;
    step(); step();
    // R1 reset state
    chk(flag == 1'b0, "R1 flag", flag, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(chan_val == 16'h0, "R1 chan", chan_val, 0);
    rst_n = 1'b1;
    step();

    // R2/R3/R8 edge sweep with running counter
    cnt = 16'hFFF0; inc = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        mode_cmp = 1'b0; edge_sel = 2'b00; pin = ~d[0];
        repeat (4) step();
        clear_flag();
        edge_sel = s[1:0]; int_en = s[0];
        prev = chan_val; pin = d[0]; c0 = cnt;
        step(); step();
        chk(flag == 1'b0, "R3 early", flag, 0);
        step();
        exp_f = (s == 3) || (s == 1 && d == 1) || (s == 2 && d == 0);
        chk(flag == exp_f, "R2 edge select", flag, exp_f);
        chk(chan_val == (exp_f ? c0 + 16'd2 : prev), "R3 capture value", chan_val,
            exp_f ? c0 + 16'd2 : prev);
        chk(irq == (int_en & exp_f), "R8 irq", irq, int_en & exp_f);
      end
    end

    // R9 flag stays set through another capture
    pin = ~pin; repeat (4) step();
    chk(flag == 1'b1, "R9 sticky", flag, 1);
    clear_flag();

    // R5 write, and capture winning over a same-cycle write
    edge_sel = 2'b11;
    write_val(16'h1234);
    chk(chan_val == 16'h1234, "R5 write", chan_val, 16'h1234);
    pin = ~pin; c0 = cnt; step(); step();
    wr_data = 16'hBEEF; wr_val = 1'b1; step(); wr_val = 1'b0;
    chk(chan_val == c0 + 16'd2, "R5 capture wins", chan_val, c0 + 16'd2);
    clear_flag();

    // R2 counter equal to channel value ignored in capture mode
    inc = 1'b0; edge_sel = 2'b00;
    write_val(16'h0500); cnt = 16'h04FF; step(); cnt = 16'h0500; repeat (3) step();
    chk(flag == 1'b0, "R2 no compare in capture", flag, 0);

    // R4 compare sweep over several targets, including wrap
    mode_cmp = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tgt = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0040 : (k == 2) ? 16'h7FFF : 16'hFFFF;
      inc = 1'b0; cnt = tgt + 16'd8; step();
      write_val(tgt);
      clear_flag();
      chk(flag == 1'b0, "R6 cleared", flag, 0);
      cnt = tgt - 16'd3; inc = 1'b1; exp_f = 1'b0;
      for (int i = 0; i < 7; i++) begin
        cur = cnt; step();
        if (cur == tgt) exp_f = 1'b1;
        chk(flag == exp_f, "R4 compare", flag, exp_f);
      end
    end

    // R4 held counter does not re-set; re-entry does
    inc = 1'b0; tgt = 16'h0040; write_val(tgt);
    cnt = tgt; step();
    chk(flag == 1'b1, "R4 hit", flag, 1);
    clear_flag(); repeat (3) step();
    chk(flag == 1'b0, "R4 held", flag, 0);
    cnt = tgt + 16'd1; step(); cnt = tgt; step();
    chk(flag == 1'b1, "R4 re-entry", flag, 1);

    // R4 pin ignored in compare mode
    clear_flag(); cnt = tgt + 16'd1; edge_sel = 2'b11; pin = ~pin; repeat (4) step();
    chk(flag == 1'b0, "R4 pin ignored", flag, 0);

    // R6 write of zero without read
    cnt = tgt; step();
    wr0 = 1'b1; step(); wr0 = 1'b0;
    chk(flag == 1'b1, "R6 write without read", flag, 1);

    // R7 event between read and write
    cnt = tgt + 16'd1;
    rd = 1'b1; step(); rd = 1'b0;
    cnt = tgt; step();
    wr0 = 1'b1; step(); wr0 = 1'b0;
    chk(flag == 1'b1, "R7 event between", flag, 1);

    // R7 event in same cycle as write
    cnt = tgt + 16'd1;
    rd = 1'b1; step(); rd = 1'b0;
    cnt = tgt; wr0 = 1'b1; step(); wr0 = 1'b0;
    chk(flag == 1'b1, "R7 event with write", flag, 1);

    // R6 read, idle, write clears; R8 irq follows
    int_en = 1'b1;
    chk(irq == 1'b1, "R8 irq set", irq, 1);
    rd = 1'b1; step(); rd = 1'b0;
    step();
    wr0 = 1'b1; step(); wr0 = 1'b0;
    chk(flag == 1'b0, "R6 gap clear", flag, 0);
    chk(irq == 1'b0, "R8 irq clear", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule